// File: doc/BRIEF.md
# Sample-Rate Output Demultiplexer

This block sits after a fast quantizer. Each sample clock it takes one data word and one overrange bit. It re-presents them on two output ports, primary and auxiliary, at the full rate, at half the rate, or at a quarter of the rate. It also drives a data-ready strobe, which downstream capture logic uses as its clock. The strobe's rising edge marks each new output word.

A synchronous active-low reset clears the output registers. It forces the internal phase counter to zero, so several converters that share one reset stay phase-aligned when they are interleaved. The same reset appears, one clock later, on a reset-out pin for external demultiplexers. The operating mode is captured only while reset is held, so a change on the mode pins waits for the next reset. Two separate enables can silence the auxiliary port.

Top module: `adc_out_demux`

## Requirements
- R1: The mode is captured from `demux_on` and `div_sel` while reset is low. `demux_on`=0 selects divide-by-1 regardless of `div_sel`. With `demux_on`=1, `div_sel`=00 selects divide-by-1, 01 selects divide-by-2, and 10 or 11 selects divide-by-4.
- R2: In divide-by-1, `pri_data` takes the sample present at each rising clock edge, one register after it, and `aux_data` stays zero.
- R3: In divide-by-2, counting edges from the first edge with reset high as edge 0, the outputs update at every odd edge k. `aux_data` then holds sample k-1 and `pri_data` holds sample k.
- R4: In divide-by-4, the outputs update at every edge k with k mod 4 = 2. `aux_data` then holds sample k-2 and `pri_data` holds sample k. Odd-numbered samples are never presented.
- R5: `dready` is a 50% square wave with period 1, 2 or 4 clocks for divide-by-1, 2 or 4. It is high in exactly the cycles after an output update in divide-by-2, and for two cycles after each update in divide-by-4. Its first rising edge comes at edge 0, edge 1 or edge 2 respectively.
- R6: In divide-by-2 and divide-by-4, `pri_data` and `ovr_out` change only at an edge where `dready` rises.
- R7: While `aux_en_a` or `aux_en_b` is low at an edge, `aux_data` is zero after that edge.
- R8: At each update, `ovr_out` is the OR of the overrange flags of the samples presented. The auxiliary sample's flag counts only while the auxiliary port is enabled.
- R9: During reset, every data output, `ovr_out` and `dready` are zero. A change on `demux_on` or `div_sel` with reset high has no effect until the next reset.
- R10: `rst_out` is high in the clock cycle after each edge where `rst_n` is low, and low otherwise, so it lasts as many clocks as the reset input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset, also phase alignment |
| demux_on | input | 1 | Demultiplexer enable, captured during reset |
| div_sel | input | 2 | Division select, captured during reset |
| aux_en_a | input | 1 | First auxiliary port enable |
| aux_en_b | input | 1 | Second auxiliary port enable |
| sample_in | input | 8 | Incoming sample word |
| ovr_in | input | 1 | Overrange flag of the incoming sample |
| pri_data | output | 8 | Primary output word (later sample of a pair) |
| aux_data | output | 8 | Auxiliary output word (earlier sample of a pair) |
| ovr_out | output | 1 | Overrange flag of the presented words |
| dready | output | 1 | Data-ready strobe for downstream capture |
| rst_out | output | 1 | Active-high reset mirror for external demultiplexers |

## Verification
The assertions check a set of properties on every cycle:
- the auxiliary port is silent in divide-by-1 and whenever an enable is low;
- the strobe alternates in divide-by-2 and has a period of four in divide-by-4;
- the primary word and the overrange flag hold still between strobe rising edges;
- the captured mode stays frozen outside reset;
- the reset mirror follows the input edges.

Some behaviour only the bench scenarios can show. These are which sample lands on which port, that odd samples are dropped in divide-by-4, how the overrange flags combine, the decode of every mode-pin combination, and that moving the mode pins without a reset changes nothing.

// File: rtl/adc_demux_pkg.sv
// Package: shared mode type and pin decode for the output demultiplexer.
// Assumes a two-bit phase counter is enough for the largest divide (4).
package adc_demux_pkg;

    typedef enum logic [1:0] {
        MODE_DIV1 = 2'd0,
        MODE_DIV2 = 2'd1,
        MODE_DIV4 = 2'd2
    } demux_mode_e;

    localparam int PHASE_W = 2;

    // Map the enable and select pins to an operating mode.
    function automatic demux_mode_e decode_mode(input logic en, input logic [1:0] sel);
        demux_mode_e m;
        if (!en) begin
            m = MODE_DIV1;
        end else begin
            case (sel)
                2'b00:   m = MODE_DIV1;
                2'b01:   m = MODE_DIV2;
                default: m = MODE_DIV4;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/adc_mode_latch.sv
// Mode capture and reset mirror.
// Samples the mode pins on every edge while reset is low and holds the
// result once reset is released. Drives an active-high copy of the reset
// delayed by one clock. Assumes the mode pins are stable through reset.
module adc_mode_latch
    import adc_demux_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        demux_on,
    input  logic [1:0]  div_sel,
    output demux_mode_e mode_q,
    output logic        rst_out
);

    demux_mode_e mode_r;
    logic        rst_out_r;

    // Capture the decoded mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= decode_mode(demux_on, div_sel);
        end
    end

    // Mirror the reset input, registered, for downstream units.
    always_ff @(posedge clk) begin
        rst_out_r <= !rst_n;
    end

    assign mode_q  = mode_r;
    assign rst_out = rst_out_r;

endmodule

// File: rtl/adc_phase_gen.sv
// Phase counter and strobe generator.
// A free-running counter, cleared by reset, selects the capture edge (the
// earlier sample of a pair) and the update edge (the outputs load). It also
// forms the registered data-ready level for the two-port modes. Assumes the
// mode stays constant while reset is high.
module adc_phase_gen
    import adc_demux_pkg::*;
#(
    parameter int PW = PHASE_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  demux_mode_e mode,
    output logic        cap_stb,
    output logic        upd_stb,
    output logic        dready_q
);

    localparam logic [PW-1:0] PH_ZERO = '0;
    localparam logic [PW-1:0] PH_ONE  = PW'(1);
    localparam logic [PW-1:0] PH_TWO  = PW'(2);

    logic [PW-1:0] ph;
    logic          dr_next;

    // Count sample clocks since reset; wraps at the largest divide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_ZERO;
        end else begin
            ph <= ph + PH_ONE;
        end
    end

    // Decode the capture and update strobes from phase and mode.
    always_comb begin
        cap_stb = 1'b0;
        upd_stb = 1'b0;
        dr_next = 1'b0;
        case (mode)
            MODE_DIV2: begin
                cap_stb = !ph[0];
                upd_stb = ph[0];
                dr_next = ph[0];
            end
            MODE_DIV4: begin
                cap_stb = (ph == PH_ZERO);
                upd_stb = (ph == PH_TWO);
                dr_next = ph[1];
            end
            default: begin
                upd_stb = 1'b1;
            end
        endcase
    end

    // Register the data-ready level so it rises together with the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dready_q <= 1'b0;
        end else begin
            dready_q <= dr_next;
        end
    end

endmodule

// File: rtl/adc_lane_pack.sv
// Output lanes.
// Holds the earlier sample of a pair and loads both ports on the update
// strobe. Forces the auxiliary port to zero whenever it is not live.
// Assumes cap_stb and upd_stb are never high together.
module adc_lane_pack #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_stb,
    input  logic          upd_stb,
    input  logic          aux_ok,
    input  logic [DW-1:0] sample_in,
    input  logic          ovr_in,
    output logic [DW-1:0] pri_q,
    output logic [DW-1:0] aux_q,
    output logic          ovr_q
);

    localparam logic [DW-1:0] ZW = '0;

    logic [DW-1:0] hold_d;
    logic          hold_o;

    // Keep the earlier sample of the pair and its flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_d <= ZW;
            hold_o <= 1'b0;
        end else if (cap_stb) begin
            hold_d <= sample_in;
            hold_o <= ovr_in;
        end
    end

    // Load the primary word and the combined overrange on each update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= ZW;
            ovr_q <= 1'b0;
        end else if (upd_stb) begin
            pri_q <= sample_in;
            ovr_q <= ovr_in | (aux_ok & hold_o);
        end
    end

    // Auxiliary word: cleared when gated off, loaded on update otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q <= ZW;
        end else if (!aux_ok) begin
            aux_q <= ZW;
        end else if (upd_stb) begin
            aux_q <= hold_d;
        end
    end

endmodule

// File: rtl/adc_out_demux.sv
// Top level of the output demultiplexer.
// Joins mode capture, phase generation and the output lanes. In divide-by-1
// the data-ready output follows the sample clock once reset is released; in
// the other modes it is the registered level from the phase generator.
// Assumes a single clock domain and a reset held for at least one edge.
module adc_out_demux
    import adc_demux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              demux_on,
    input  logic [1:0]        div_sel,
    input  logic              aux_en_a,
    input  logic              aux_en_b,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              ovr_in,
    output logic [DATA_W-1:0] pri_data,
    output logic [DATA_W-1:0] aux_data,
    output logic              ovr_out,
    output logic              dready,
    output logic              rst_out
);

    demux_mode_e mode_q;
    logic        cap_stb;
    logic        upd_stb;
    logic        dready_q;
    logic        aux_ok;
    logic        rst_out_w;

    adc_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .demux_on (demux_on),
        .div_sel  (div_sel),
        .mode_q   (mode_q),
        .rst_out  (rst_out_w)
    );

    adc_phase_gen #(.PW(PHASE_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .cap_stb  (cap_stb),
        .upd_stb  (upd_stb),
        .dready_q (dready_q)
    );

    // Auxiliary port is live only with both enables and a two-port mode.
    assign aux_ok = aux_en_a & aux_en_b & (mode_q != MODE_DIV1);

    adc_lane_pack #(.DW(DATA_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stb   (cap_stb),
        .upd_stb   (upd_stb),
        .aux_ok    (aux_ok),
        .sample_in (sample_in),
        .ovr_in    (ovr_in),
        .pri_q     (pri_data),
        .aux_q     (aux_data),
        .ovr_q     (ovr_out)
    );

    // Select the data-ready source by mode.
    assign dready  = (mode_q == MODE_DIV1) ? (clk & ~rst_out_w) : dready_q;
    assign rst_out = rst_out_w;

endmodule

// File: rtl/adc_out_demux_chk.sv
// Checker for the output demultiplexer, bound into every instance.
// Assumes the reset is driven low from time zero.
module adc_out_demux_chk
    import adc_demux_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input demux_mode_e   mode,
    input logic          aux_en_a,
    input logic          aux_en_b,
    input logic [DW-1:0] pri_data,
    input logic [DW-1:0] aux_data,
    input logic          ovr_out,
    input logic          dready_q,
    input logic          rst_out
);

    logic seen = 1'b0;
    logic live1, live2, live3;

    // Track how many consecutive edges have passed with reset high.
    always_ff @(posedge clk) begin
        seen  <= 1'b1;
        live1 <= rst_n;
        live2 <= rst_n & live1;
        live3 <= rst_n & live2;
    end

    a_r2_aux_zero_div1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIV1) |=> (aux_data == '0));

    a_r7_aux_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(aux_en_a && aux_en_b) |=> (aux_data == '0));

    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (live2 && mode != MODE_DIV1 && !$rose(dready_q))
            |-> ($stable(pri_data) && $stable(ovr_out)));

    a_r5_div2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (live2 && mode == MODE_DIV2) |-> (dready_q != $past(dready_q)));

    a_r5_div4_period: assert property (@(posedge clk) disable iff (!rst_n)
        (live3 && mode == MODE_DIV4) |-> (dready_q != $past(dready_q, 2)));

    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        live1 |-> $stable(mode));

    a_r10_rst_fall: assert property (@(posedge clk) disable iff (!seen)
        $fell(rst_n) |=> rst_out);

    a_r10_rst_rise: assert property (@(posedge clk) disable iff (!seen)
        $rose(rst_n) |=> !rst_out);

endmodule

bind adc_out_demux adc_out_demux_chk #(.DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .aux_en_a (aux_en_a),
    .aux_en_b (aux_en_b),
    .pri_data (pri_data),
    .aux_data (aux_data),
    .ovr_out  (ovr_out),
    .dready_q (dready_q),
    .rst_out  (rst_out)
);

// File: tb/adc_out_demux_test.sv
module adc_out_demux_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       demux_on = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       aux_en_a = 1'b1;
    logic       aux_en_b = 1'b1;
    logic [7:0] sample_in = 8'h00;
    logic       ovr_in = 1'b0;
    logic [7:0] pri_data, aux_data;
    logic       ovr_out, dready, rst_out;

    always #2 clk = ~clk;   // 250 MHz

    adc_out_demux uut (
        .clk(clk), .rst_n(rst_n), .demux_on(demux_on), .div_sel(div_sel),
        .aux_en_a(aux_en_a), .aux_en_b(aux_en_b), .sample_in(sample_in),
        .ovr_in(ovr_in), .pri_data(pri_data), .aux_data(aux_data),
        .ovr_out(ovr_out), .dready(dready), .rst_out(rst_out)
    );

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    int    bm;          // bench mode: 0 div1, 1 div2, 2 div4
    int    k;
    logic [7:0] hs, ep, ea;
    logic  ho, eo;
    string tag_over = "";

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Mode decode written from R1.
    function automatic int exp_mode(input logic on, input logic [1:0] sel);
        if (!on) return 0;
        if (sel == 2'b00) return 0;
        if (sel == 2'b01) return 1;
        return 2;
    endfunction

    function automatic string mode_req(input int m);
        if (m == 0) return "R2";
        if (m == 1) return "R3";
        return "R4";
    endfunction

    // Hold reset for len edges (R9, R10), then release with the model cleared.
    task automatic do_reset(input logic on, input logic [1:0] sel, input int len);
        @(negedge clk);
        demux_on = on;
        div_sel  = sel;
        rst_n    = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            chk("R10", "rst_out in reset", rst_out, 1);
            chk("R9", "pri in reset", pri_data, 0);
            chk("R9", "aux in reset", aux_data, 0);
            chk("R9", "ovr in reset", ovr_out, 0);
            chk("R9", "dready in reset", dready, 0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        bm = exp_mode(on, sel);
        k = 0; hs = 0; ho = 0; ep = 0; ea = 0; eo = 0;
    endtask

    // Drive one sample, advance one edge, update the model and check.
    task automatic step(input logic [7:0] s, input logic o);
        logic aux_ok, upd, cap, edr;
        string rq;
        sample_in = s;
        ovr_in    = o;
        @(posedge clk); #1;
        aux_ok = aux_en_a & aux_en_b & (bm != 0);
        upd = (bm == 0) ? 1'b1 : (bm == 1) ? (k % 2 == 1) : (k % 4 == 2);
        cap = (bm == 1) ? (k % 2 == 0) : (bm == 2) ? (k % 4 == 0) : 1'b0;
        edr = (bm == 0) ? 1'b1 : (bm == 1) ? (k % 2 == 1) : (k % 4 >= 2);
        if (upd) begin
            ep = s;
            eo = o | (aux_ok & ho);
            ea = aux_ok ? hs : 8'h00;
        end
        if (!aux_ok) ea = 8'h00;
        if (cap) begin
            hs = s;
            ho = o;
        end
        rq = (tag_over != "") ? tag_over : (upd ? mode_req(bm) : "R6");
        chk(rq, "pri_data", pri_data, ep);
        chk(aux_ok ? rq : "R7", "aux_data", aux_data, ea);
        chk((tag_over != "") ? tag_over : "R8", "ovr_out", ovr_out, eo);
        chk("R5", "dready", dready, edr);
        if (k == 0) chk("R10", "rst_out after release", rst_out, 0);
        k++;
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);

        // R1: demux_on low overrides a two-port select.
        do_reset(1'b0, 2'b01, 2);
        step(8'h00, 0); step(8'hFF, 1); step(8'h5A, 0); step(8'hA5, 1);
        step(8'h01, 0); step(8'h80, 0);
        tag_over = "R1";
        step(8'h7F, 1);
        tag_over = "";

        // R3 directed pairs with overrange on either side.
        do_reset(1'b1, 2'b01, 3);
        step(8'h11, 1); step(8'h22, 0); step(8'h33, 0); step(8'h44, 1);
        step(8'hFF, 0); step(8'h00, 0); step(8'h00, 0); step(8'hFF, 0);

        // R4 directed: odd samples carry overrange and must vanish.
        do_reset(1'b1, 2'b10, 1);
        for (int i = 0; i < 12; i++) step(8'(8'h10 + i), (i % 2 == 1));

        // R1: select 11 also means divide-by-4.
        do_reset(1'b1, 2'b11, 2);
        for (int i = 0; i < 8; i++) step(8'(8'hC0 + i), 1'b0);

        // R9: mode pins moved with reset high are ignored.
        do_reset(1'b1, 2'b01, 2);
        step(8'hA1, 0); step(8'hA2, 0); step(8'hA3, 0); step(8'hA4, 0);
        demux_on = 1'b0;
        div_sel  = 2'b10;
        tag_over = "R9";
        for (int i = 0; i < 8; i++) step(8'(8'hB0 + i), (i == 2));
        tag_over = "";

        // R7: one enable low silences aux; re-enable mid-run.
        aux_en_b = 1'b0;
        do_reset(1'b1, 2'b10, 2);
        for (int i = 0; i < 8; i++) step(8'(8'hD0 + i), 1'b1);
        aux_en_b = 1'b1;
        aux_en_a = 1'b0;
        for (int i = 0; i < 4; i++) step(8'(8'hE0 + i), 1'b0);
        aux_en_a = 1'b1;
        for (int i = 0; i < 8; i++) step(8'(8'hF0 + i), 1'b0);

        // Random runs across modes, reset lengths and enable changes.
        for (int r = 0; r < 40; r++) begin
            logic       on;
            logic [1:0] sel;
            int         n;
            on  = 1'($urandom % 2);
            sel = 2'($urandom % 4);
            aux_en_a = ($urandom % 6) != 0;
            aux_en_b = ($urandom % 6) != 0;
            do_reset(on, sel, 1 + int'($urandom % 4));
            n = 16 + int'($urandom % 24);
            for (int i = 0; i < n; i++) begin
                if ($urandom % 10 == 0) aux_en_a = ~aux_en_a;
                if ($urandom % 10 == 0) aux_en_b = ~aux_en_b;
                step(8'($urandom), 1'($urandom % 4 == 0));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule